// File: doc/BRIEF.md
# Transformer Flux Balance Controller

This block keeps the transformer of a dual-active-bridge converter out of saturation. It watches the primary and secondary winding currents and rebuilds the magnetizing current as their difference. The secondary winding current is first scaled by a programmable turns-ratio gain. In each switching period the block takes two samples of that current, half a period apart. It then estimates the period's DC (switching-average) part and its peak-to-peak swing. From the average it produces a proportional correction to the primary bridge's duty cycle.

The secondary bridge's sync pulse sets the rhythm. Each pulse starts a fresh pair of samples. Each pulse also turns the pair gathered in the period just ended into a new average, a new swing and a new duty trim. The trim is clamped to a symmetric programmable bound and held until the next update. If the sync pulses stop, a watchdog clears the trim to zero and raises a flag until a pulse arrives again.

Top module: `flux_trim_ctrl`

## Requirements
- R1: While reset is high and after it, until the first update: `duty_trim`, `mag_avg`, `mag_pp`, `trim_valid` and `sync_lost` are all zero.
- R2: A magnetizing sample equals `i_pri` minus floor(`i_sec` × `ratio_gain` / 4096). Here `ratio_gain` is unsigned with 12 fraction bits.
- R3: After a sync pulse, only the first two cycles with `smp_valid` high are kept, as sample A and then sample B. Later strobes in the same period have no effect. A strobe in the same cycle as the sync pulse becomes sample A of the new period.
- R4: A sync pulse with both samples held produces an update. In the cycle after the pulse, `mag_avg` = floor((A+B)/2) and `mag_pp` = |A−B|, and `trim_valid` is high for exactly that one cycle.
- R5: The updated `duty_trim` is −floor(`mag_avg` × `kp_gain` / 1024), clamped to the range −`trim_limit` … +`trim_limit`. Here `kp_gain` is signed with 10 fraction bits.
- R6: A sync pulse with fewer than two samples leaves `duty_trim`, `mag_avg` and `mag_pp` unchanged and gives no `trim_valid`. Between updates `duty_trim` holds its value.
- R7: If TIMEOUT clock cycles pass with no sync pulse, `duty_trim` becomes 0 and `sync_lost` becomes 1. The count runs from the last sync pulse, or from reset if no pulse has come yet. The change appears TIMEOUT cycles after the last sync edge, and not one cycle earlier.
- R8: Any sync pulse clears `sync_lost` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Current samples are valid this cycle |
| i_pri | input | 16 | Primary winding current, signed |
| i_sec | input | 16 | Secondary winding current, signed |
| sync_pulse | input | 1 | Secondary bridge sync, one cycle per switching period |
| ratio_gain | input | 16 | Turns-ratio gain, unsigned, 12 fraction bits |
| kp_gain | input | 16 | Proportional gain, signed, 10 fraction bits |
| trim_limit | input | 15 | Magnitude bound of the duty trim |
| duty_trim | output | 16 | Signed primary duty correction |
| trim_valid | output | 1 | One-cycle strobe marking a new trim |
| mag_avg | output | 21 | Signed switching-average magnetizing current |
| mag_pp | output | 22 | Peak-to-peak magnetizing current |
| sync_lost | output | 1 | Sync watchdog expired |

## Verification
The assertions check the rules that hold on every cycle:
- an update always follows a sync pulse and stays inside the clamp bound;
- the trim never moves without an update or a watchdog expiry;
- a sync pulse always restarts sample collection;
- a watchdog expiry always leaves a zero trim;
- a sync pulse always clears the lost flag.

The arithmetic itself can only be shown by the bench's scenarios, with values worked out independently: the turns-ratio scaling with floor rounding of negative products, the average and swing, the clamp on both signs, dropped extra strobes, short periods and the exact cycle the watchdog expires.

// File: rtl/flux_pkg.sv
package flux_pkg;

    localparam int DEF_CUR_W      = 16;
    localparam int DEF_RATIO_W    = 16;
    localparam int DEF_RATIO_FRAC = 12;
    localparam int DEF_KP_W       = 16;
    localparam int DEF_KP_FRAC    = 10;
    localparam int DEF_TRIM_W     = 16;
    localparam int DEF_TIMEOUT    = 2048;

    // Progress of the sample pair inside one switching period.
    typedef enum logic [1:0] {
        SLOT_A    = 2'd0,
        SLOT_B    = 2'd1,
        SLOT_FULL = 2'd2
    } slot_e;

endpackage

// File: rtl/flux_mag_calc.sv
module flux_mag_calc #(
    parameter int CUR_W      = flux_pkg::DEF_CUR_W,
    parameter int RATIO_W    = flux_pkg::DEF_RATIO_W,
    parameter int RATIO_FRAC = flux_pkg::DEF_RATIO_FRAC,
    localparam int MAG_W     = CUR_W + RATIO_W - RATIO_FRAC + 1
) (
    input  logic signed [CUR_W-1:0]   i_pri,
    input  logic signed [CUR_W-1:0]   i_sec,
    input  logic        [RATIO_W-1:0] ratio_gain,
    output logic signed [MAG_W-1:0]   mag_o
);
    localparam int PROD_W = CUR_W + RATIO_W + 1;

    logic signed [PROD_W-1:0] sec_scaled;

    // Secondary current referred to the primary side (floor rounding).
    assign sec_scaled = i_sec * $signed({1'b0, ratio_gain});
    assign mag_o      = MAG_W'(i_pri) - MAG_W'(sec_scaled >>> RATIO_FRAC);

endmodule

// File: rtl/flux_sample_pair.sv
module flux_sample_pair
    import flux_pkg::*;
#(
    parameter int MAG_W = 21
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sync_i,
    input  logic                    valid_i,
    input  logic signed [MAG_W-1:0] mag_i,
    output logic signed [MAG_W-1:0] smp_a_o,
    output logic signed [MAG_W-1:0] smp_b_o,
    output logic                    full_o
);
    slot_e slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= SLOT_A;
            smp_a_o <= '0;
            smp_b_o <= '0;
        end else if (sync_i) begin
            if (valid_i) begin
                smp_a_o <= mag_i;
                slot_q  <= SLOT_B;
            end else begin
                slot_q  <= SLOT_A;
            end
        end else if (valid_i) begin
            case (slot_q)
                SLOT_A: begin
                    smp_a_o <= mag_i;
                    slot_q  <= SLOT_B;
                end
                SLOT_B: begin
                    smp_b_o <= mag_i;
                    slot_q  <= SLOT_FULL;
                end
                default: slot_q <= slot_q;
            endcase
        end
    end

    assign full_o = (slot_q == SLOT_FULL);

    // R3: a sync pulse always starts a new pair, so it can never be full next cycle
    a_r3_sync_restarts_pair: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> (slot_q != SLOT_FULL));

endmodule

// File: rtl/flux_trim_loop.sv
module flux_trim_loop #(
    parameter int MAG_W   = 21,
    parameter int KP_W    = flux_pkg::DEF_KP_W,
    parameter int KP_FRAC = flux_pkg::DEF_KP_FRAC,
    parameter int TRIM_W  = flux_pkg::DEF_TRIM_W,
    parameter int TIMEOUT = flux_pkg::DEF_TIMEOUT
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sync_i,
    input  logic                    full_i,
    input  logic signed [MAG_W-1:0] smp_a_i,
    input  logic signed [MAG_W-1:0] smp_b_i,
    input  logic signed [KP_W-1:0]  kp_i,
    input  logic        [TRIM_W-2:0] limit_i,
    output logic signed [TRIM_W-1:0] trim_o,
    output logic                    trim_valid_o,
    output logic signed [MAG_W-1:0] avg_o,
    output logic        [MAG_W:0]   pp_o,
    output logic                    lost_o
);
    localparam int PROD_W = MAG_W + KP_W;
    localparam int TMO_W  = $clog2(TIMEOUT + 1);

    logic signed [MAG_W:0]    pair_sum, pair_diff;
    logic signed [MAG_W-1:0]  avg_next;
    logic        [MAG_W:0]    pp_next;
    logic signed [PROD_W-1:0] p_prod, p_shift;
    logic signed [PROD_W:0]   p_neg, lim_ext;
    logic signed [TRIM_W-1:0] trim_next;
    logic [TMO_W-1:0]         tmo_q;
    logic                     do_update, tmo_fire;

    // Average and swing of the pair.
    assign pair_sum  = (MAG_W+1)'(smp_a_i) + (MAG_W+1)'(smp_b_i);
    assign pair_diff = (MAG_W+1)'(smp_a_i) - (MAG_W+1)'(smp_b_i);
    assign avg_next  = MAG_W'(pair_sum >>> 1);
    assign pp_next   = pair_diff[MAG_W] ? $unsigned(-pair_diff) : $unsigned(pair_diff);

    // Proportional law, sign opposing the DC offset, then the symmetric clamp.
    assign p_prod  = avg_next * kp_i;
    assign p_shift = p_prod >>> KP_FRAC;
    assign p_neg   = -{p_shift[PROD_W-1], p_shift};
    assign lim_ext = (PROD_W+1)'({1'b0, limit_i});

    always_comb begin
        if (p_neg > lim_ext)
            trim_next = TRIM_W'(lim_ext);
        else if (p_neg < -lim_ext)
            trim_next = TRIM_W'(-lim_ext);
        else
            trim_next = TRIM_W'(p_neg);
    end

    assign do_update = sync_i && full_i;
    assign tmo_fire  = !sync_i && (tmo_q == TMO_W'(TIMEOUT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tmo_q        <= '0;
            lost_o       <= 1'b0;
            trim_o       <= '0;
            trim_valid_o <= 1'b0;
            avg_o        <= '0;
            pp_o         <= '0;
        end else begin
            trim_valid_o <= do_update;
            if (sync_i) begin
                tmo_q  <= '0;
                lost_o <= 1'b0;
            end else if (tmo_q != TMO_W'(TIMEOUT)) begin
                tmo_q <= tmo_q + 1'b1;
            end
            if (do_update) begin
                trim_o <= trim_next;
                avg_o  <= avg_next;
                pp_o   <= pp_next;
            end else if (tmo_fire) begin
                trim_o <= '0;
                lost_o <= 1'b1;
            end
        end
    end

    logic signed [TRIM_W:0] trim_wide, lim_wide;
    assign trim_wide = {trim_o[TRIM_W-1], trim_o};
    assign lim_wide  = {2'b00, limit_i};

    // R4: a fresh trim only ever follows a sync pulse
    a_r4_update_follows_sync: assert property (@(posedge clk) disable iff (rst)
        trim_valid_o |-> $past(sync_i));

    // R5: every new trim stays inside the bound in force when it was computed
    a_r5_trim_in_limit: assert property (@(posedge clk) disable iff (rst)
        trim_valid_o |-> (trim_wide <= $past(lim_wide)) && (trim_wide >= -$past(lim_wide)));

    // R6: with neither update nor watchdog expiry the trim does not move
    a_r6_trim_hold: assert property (@(posedge clk) disable iff (rst)
        !(sync_i && full_i) && (tmo_q != TMO_W'(TIMEOUT - 1)) |=> $stable(trim_o));

    // R7: the watchdog flag is raised together with a zero trim
    a_r7_timeout_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_o) |-> (trim_o == '0));

    // R8: any sync pulse clears the lost flag
    a_r8_sync_clears_lost: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> !lost_o);

endmodule

// File: rtl/flux_trim_ctrl.sv
module flux_trim_ctrl #(
    parameter int CUR_W      = flux_pkg::DEF_CUR_W,
    parameter int RATIO_W    = flux_pkg::DEF_RATIO_W,
    parameter int RATIO_FRAC = flux_pkg::DEF_RATIO_FRAC,
    parameter int KP_W       = flux_pkg::DEF_KP_W,
    parameter int KP_FRAC    = flux_pkg::DEF_KP_FRAC,
    parameter int TRIM_W     = flux_pkg::DEF_TRIM_W,
    parameter int TIMEOUT    = flux_pkg::DEF_TIMEOUT
) (
    input  logic                                            clk,
    input  logic                                            rst,
    input  logic                                            smp_valid,
    input  logic signed [CUR_W-1:0]                         i_pri,
    input  logic signed [CUR_W-1:0]                         i_sec,
    input  logic                                            sync_pulse,
    input  logic        [RATIO_W-1:0]                       ratio_gain,
    input  logic signed [KP_W-1:0]                          kp_gain,
    input  logic        [TRIM_W-2:0]                        trim_limit,
    output logic signed [TRIM_W-1:0]                        duty_trim,
    output logic                                            trim_valid,
    output logic signed [CUR_W+RATIO_W-RATIO_FRAC:0]        mag_avg,
    output logic        [CUR_W+RATIO_W-RATIO_FRAC+1:0]      mag_pp,
    output logic                                            sync_lost
);
    localparam int MAG_W = CUR_W + RATIO_W - RATIO_FRAC + 1;

    logic signed [MAG_W-1:0] mag_now, smp_a, smp_b;
    logic                    pair_full;

    flux_mag_calc #(
        .CUR_W      (CUR_W),
        .RATIO_W    (RATIO_W),
        .RATIO_FRAC (RATIO_FRAC)
    ) u_calc (
        .i_pri      (i_pri),
        .i_sec      (i_sec),
        .ratio_gain (ratio_gain),
        .mag_o      (mag_now)
    );

    flux_sample_pair #(
        .MAG_W (MAG_W)
    ) u_pair (
        .clk     (clk),
        .rst     (rst),
        .sync_i  (sync_pulse),
        .valid_i (smp_valid),
        .mag_i   (mag_now),
        .smp_a_o (smp_a),
        .smp_b_o (smp_b),
        .full_o  (pair_full)
    );

    flux_trim_loop #(
        .MAG_W   (MAG_W),
        .KP_W    (KP_W),
        .KP_FRAC (KP_FRAC),
        .TRIM_W  (TRIM_W),
        .TIMEOUT (TIMEOUT)
    ) u_loop (
        .clk          (clk),
        .rst          (rst),
        .sync_i       (sync_pulse),
        .full_i       (pair_full),
        .smp_a_i      (smp_a),
        .smp_b_i      (smp_b),
        .kp_i         (kp_gain),
        .limit_i      (trim_limit),
        .trim_o       (duty_trim),
        .trim_valid_o (trim_valid),
        .avg_o        (mag_avg),
        .pp_o         (mag_pp),
        .lost_o       (sync_lost)
    );

endmodule

// File: tb/flux_trim_ctrl_bench.sv
module flux_trim_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 2048;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_valid = 1'b0;
    logic signed [15:0] i_pri = '0;
    logic signed [15:0] i_sec = '0;
    logic               sync_pulse = 1'b0;
    logic        [15:0] ratio_gain = 16'd4096;
    logic signed [15:0] kp_gain = 16'sd1024;
    logic        [14:0] trim_limit = 15'd1000;
    logic signed [15:0] duty_trim;
    logic               trim_valid;
    logic signed [20:0] mag_avg;
    logic        [21:0] mag_pp;
    logic               sync_lost;

    int n_checks = 0;
    int n_fail   = 0;

    longint exp_trim = 0, exp_avg = 0, exp_pp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flux_trim_ctrl #(.TIMEOUT(TMO)) u_flux_trim_ctrl (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .i_pri(i_pri), .i_sec(i_sec),
        .sync_pulse(sync_pulse), .ratio_gain(ratio_gain), .kp_gain(kp_gain),
        .trim_limit(trim_limit), .duty_trim(duty_trim), .trim_valid(trim_valid),
        .mag_avg(mag_avg), .mag_pp(mag_pp), .sync_lost(sync_lost)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint mag_model(longint p, longint s);
        return p - ((s * longint'(ratio_gain)) >>> 12);
    endfunction

    function automatic void predict(longint a, longint b);
        longint t;
        exp_avg = (a + b) >>> 1;
        exp_pp  = (a > b) ? a - b : b - a;
        t = -((exp_avg * longint'(kp_gain)) >>> 10);
        if (t > longint'(trim_limit)) t = longint'(trim_limit);
        if (t < -longint'(trim_limit)) t = -longint'(trim_limit);
        exp_trim = t;
    endfunction

    task automatic send(input longint p, input longint s);
        @(negedge clk);
        smp_valid = 1'b1; i_pri = 16'(p); i_sec = 16'(s);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Sync pulse, optionally with a sample in the same cycle; returns at the
    // falling edge after the sync edge, where registered results are visible.
    task automatic sync_edge(input bit with_smp, input longint p, input longint s);
        @(negedge clk);
        sync_pulse = 1'b1;
        smp_valid = with_smp; i_pri = 16'(p); i_sec = 16'(s);
        @(negedge clk);
        sync_pulse = 1'b0; smp_valid = 1'b0;
    endtask

    task automatic check_outputs(input string req, input bit upd);
        chk(req, "duty_trim", duty_trim, exp_trim);
        chk(req, "mag_avg", mag_avg, exp_avg);
        chk(req, "mag_pp", longint'(mag_pp), exp_pp);
        chk(req, "trim_valid", trim_valid, upd);
    endtask

    task automatic t_reset;
        chk("R1", "duty_trim", duty_trim, 0);
        chk("R1", "mag_avg", mag_avg, 0);
        chk("R1", "mag_pp", longint'(mag_pp), 0);
        chk("R1", "trim_valid", trim_valid, 0);
        chk("R1", "sync_lost", sync_lost, 0);
    endtask

    // Plain period, unity turns ratio
    task automatic t_basic;
        sync_edge(0, 0, 0);
        send(100, 40); send(60, 30);
        predict(60, 30);
        sync_edge(0, 0, 0);
        check_outputs("R4", 1);
        @(negedge clk);
        chk("R4", "trim_valid one cycle", trim_valid, 0);
    endtask

    // Fractional turns ratio with negative products (floor rounding)
    task automatic t_ratio;
        longint a, b;
        ratio_gain = 16'd10240;
        a = mag_model(10, -7); b = mag_model(-5, 3);
        send(10, -7); send(-5, 3);
        predict(a, b);
        sync_edge(0, 0, 0);
        check_outputs("R2", 1);
        a = mag_model(-301, 1234); b = mag_model(77, -999);
        send(-301, 1234); send(77, -999);
        predict(a, b);
        sync_edge(0, 0, 0);
        check_outputs("R2", 1);
        ratio_gain = 16'd4096;
    endtask

    // Clamp on both signs, and a mid-range gain
    task automatic t_clamp;
        trim_limit = 15'd500; kp_gain = 16'sd3072;
        send(2000, 0); send(1000, 0);
        predict(2000, 1000);
        sync_edge(0, 0, 0);
        check_outputs("R5", 1);
        chk("R5", "negative clamp", duty_trim, -500);
        send(-3000, 0); send(-1001, 0);
        predict(-3000, -1001);
        sync_edge(0, 0, 0);
        check_outputs("R5", 1);
        chk("R5", "positive clamp", duty_trim, 500);
        kp_gain = -16'sd512; trim_limit = 15'd1000;
        send(-7, 0); send(0, 0);
        predict(-7, 0);
        sync_edge(0, 0, 0);
        check_outputs("R5", 1);
        kp_gain = 16'sd1024;
    endtask

    // Extra strobes dropped; a strobe on the sync cycle opens the new pair
    task automatic t_extra;
        send(40, 0); send(20, 0); send(9000, 0); send(-9000, 0);
        predict(40, 20);
        sync_edge(1, 300, 0);
        check_outputs("R3", 1);
        send(100, 0); send(-5000, 0);
        predict(300, 100);
        sync_edge(0, 0, 0);
        check_outputs("R3", 1);
    endtask

    // Short period leaves everything as it was
    task automatic t_short;
        send(8000, 0);
        sync_edge(0, 0, 0);
        check_outputs("R6", 0);
        sync_edge(0, 0, 0);
        check_outputs("R6", 0);
        repeat (5) @(negedge clk);
        chk("R6", "trim held", duty_trim, exp_trim);
    endtask

    // Watchdog expiry at exactly TMO cycles, then recovery
    task automatic t_timeout;
        send(-400, 0); send(-200, 0);
        predict(-400, -200);
        sync_edge(0, 0, 0);
        check_outputs("R7", 1);
        repeat (TMO - 1) @(negedge clk);
        chk("R7", "sync_lost before expiry", sync_lost, 0);
        chk("R7", "trim before expiry", duty_trim, exp_trim);
        @(negedge clk);
        chk("R7", "sync_lost at expiry", sync_lost, 1);
        chk("R7", "trim at expiry", duty_trim, 0);
        exp_trim = 0;
        send(50, 0); send(10, 0);
        predict(50, 10);
        sync_edge(0, 0, 0);
        chk("R8", "sync_lost cleared", sync_lost, 0);
        check_outputs("R8", 1);
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) #1;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_ratio();
        t_clamp();
        t_extra();
        t_short();
        t_timeout();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule